// File: doc/BRIEF.md
# Predict-Taken Branch Fetch Steering

This block drives the fetch address of a five-stage in-order pipeline whose only conditional branch is a branch-on-zero. The fetch PC goes to instruction memory, and the word that comes back is decoded in the same cycle. If the word is a branch, the next fetch goes to the branch target. The unit does not wait for the condition, so every branch is statically guessed as taken. The target is the branch's own PC plus its sign-extended offset, scaled to a word address.

Each fetched instruction enters an internal slot record that follows the fetch/decode and decode/execute buffers of the datapath. The record holds whether the slot is live, whether it is a branch, and the sequential fall-through address. When a branch reaches execute, the datapath reports whether its tested operand is zero. A nonzero operand means the guess was wrong. In that cycle the unit restores the saved fall-through address, and it tells the datapath to load no-ops into both younger buffers. A recovery always wins over a redirect requested by the word being fetched in the same cycle.

Instruction words arrive as a valid-qualified stream with no ready signal. The unit accepts every word marked valid in the cycle it is presented, so it never applies back-pressure. A cycle with valid low holds the PC and puts an empty slot into the pipe. The resolve and flush pins are plain control signals.

Top module: `taken_fetch`

## Requirements
- R1: While reset is asserted, and after it is released, `pc_o` equals `RESET_PC` (default 0) and `redirect_o`, `recover_o`, `fd_flush_o` and `dx_flush_o` are low until the first accepted word.
- R2: A valid word that is not a branch advances the PC by 4 at the next clock edge.
- R3: With `insn_valid_i` low and no recovery, the PC keeps its value and `redirect_o` stays low.
- R4: A valid word whose bits [31:26] equal 6'h04 is a branch. In that cycle `redirect_o` is high, and at the next edge the PC becomes the current PC plus the sign-extended bits [15:0] shifted left by 2. This happens whatever value `ex_zero_i` has.
- R5: A branch accepted in cycle t is resolved in cycle t+2, provided no recovery happens in between. If `ex_zero_i` is high in that cycle, no recovery occurs and fetch continues on the target path.
- R6: If `ex_zero_i` is low while a branch is in execute, `recover_o` is high and the PC becomes that branch's address plus 4 at the next edge.
- R7: `fd_flush_o` and `dx_flush_o` are high exactly in the cycles in which `recover_o` is high.
- R8: If a recovery and a branch fetch occur in the same cycle, the recovery decides the next PC and `redirect_o` stays low.
- R9: `ex_zero_i` has no effect when the execute slot holds a non-branch, an empty slot, or a slot flushed by a recovery. In particular, a recovery is never followed by another recovery in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_i | input | 32 | Instruction word read at `pc_o` |
| insn_valid_i | input | 1 | `insn_i` holds a fetched word this cycle |
| ex_zero_i | input | 1 | Operand tested by the branch in execute is zero |
| pc_o | output | 32 | Current fetch address |
| redirect_o | output | 1 | Fetched word is a branch; next PC is its target |
| recover_o | output | 1 | Branch in execute was mispredicted |
| fd_flush_o | output | 1 | Load a no-op into the fetch/decode buffer at this edge |
| dx_flush_o | output | 1 | Load a no-op into the decode/execute buffer at this edge |

## Verification
The assertions check four things on every clock cycle. The next PC must be the right choice among recovery address, target, hold and sequential step. A branch must reach the execute slot two cycles after it is accepted unless a recovery intervenes. Recoveries must never occur in two consecutive cycles, and a recovery must never coincide with a redirect. The cross-cycle matters need the bench's scenarios. These are that the restored address belongs to the particular branch fetched two cycles earlier, that flushed wrong-path branches are never resolved, and that the operand flag is ignored on non-branch slots. The bench drives long random streams of branches, bubbles and outcomes to cover them.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int unsigned PC_W = 32;

  // Record that follows one fetched word down the pipe
  typedef struct packed {
    logic            live;
    logic            is_br;
    logic [PC_W-1:0] fall_pc;
  } slot_t;
endpackage

// File: rtl/br_decode.sv
module br_decode
  import fetch_pkg::*;
#(
  parameter int unsigned INSN_W   = 32,
  parameter int unsigned OPC_LSB  = 26,
  parameter int unsigned OPC_W    = 6,
  parameter logic [OPC_W-1:0] BR_OPC = 6'h04,
  parameter int unsigned OFF_W    = 16,
  parameter int unsigned ALIGN_SH = 2
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [INSN_W-1:0] insn,
  input  logic              insn_valid,
  output logic              is_br,
  output logic [PC_W-1:0]   target,
  output logic [PC_W-1:0]   seq_pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(1) << ALIGN_SH;
  localparam int unsigned EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] off_ext;
  logic [PC_W-1:0] off_sh;

  always_comb begin
    is_br   = insn_valid && (insn[OPC_LSB +: OPC_W] == BR_OPC);
    off_ext = {{EXT_W{insn[OFF_W-1]}}, insn[OFF_W-1:0]};
    off_sh  = off_ext << ALIGN_SH;
    target  = pc + off_sh;
    seq_pc  = pc + STEP;
  end

  always_comb begin
    if (!insn_valid) a_r3_no_decode_idle: assert (!is_br);
  end
endmodule

// File: rtl/slot_track.sv
module slot_track
  import fetch_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  slot_t fetch_slot,
  input  logic  ex_zero,
  output slot_t dx_slot,
  output logic  mispredict,
  output logic  fd_flush,
  output logic  dx_flush
);
  slot_t fd_q, dx_q;

  always_comb begin
    mispredict = dx_q.live && dx_q.is_br && !ex_zero;
    fd_flush   = mispredict;
    dx_flush   = mispredict;
    dx_slot    = dx_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fd_q <= '0;
      dx_q <= '0;
    end else begin
      fd_q <= mispredict ? '0 : fetch_slot;
      dx_q <= mispredict ? '0 : fd_q;
    end
  end

  // R9: flushed slots are never resolved
  a_r9_no_double_recover: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |=> !mispredict);

  // R5: an accepted branch sits in execute two cycles later
  a_r5_resolve_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_slot.live && fetch_slot.is_br && !mispredict) ##1 !mispredict
      |=> (dx_q.live && dx_q.is_br));
endmodule

// File: rtl/pc_unit.sv
module pc_unit
  import fetch_pkg::*;
#(
  parameter logic [PC_W-1:0] RESET_PC = '0,
  parameter int unsigned ALIGN_SH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_valid,
  input  logic            redirect,
  input  logic [PC_W-1:0] target,
  input  logic [PC_W-1:0] seq_pc,
  input  logic            recover,
  input  logic [PC_W-1:0] recover_pc,
  output logic [PC_W-1:0] pc_q
);
  localparam logic [PC_W-1:0] STEP = PC_W'(1) << ALIGN_SH;

  logic [PC_W-1:0] pc_d;

  always_comb begin
    if (recover)          pc_d = recover_pc;
    else if (!insn_valid) pc_d = pc_q;
    else if (redirect)    pc_d = target;
    else                  pc_d = seq_pc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_d;
  end

  a_r6_restore_pc: assert property (@(posedge clk) disable iff (!rst_n)
    recover |=> pc_q == $past(recover_pc));

  a_r4_take_target: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !recover) |=> pc_q == $past(target));

  a_r3_hold_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (!insn_valid && !recover) |=> $stable(pc_q));

  a_r2_step_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !redirect && !recover) |=> pc_q == $past(pc_q) + STEP);
endmodule

// File: rtl/taken_fetch.sv
module taken_fetch
  import fetch_pkg::*;
#(
  parameter int unsigned INSN_W   = 32,
  parameter int unsigned OPC_LSB  = 26,
  parameter int unsigned OPC_W    = 6,
  parameter logic [OPC_W-1:0] BR_OPC = 6'h04,
  parameter int unsigned OFF_W    = 16,
  parameter int unsigned ALIGN_SH = 2,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INSN_W-1:0] insn_i,
  input  logic              insn_valid_i,
  input  logic              ex_zero_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              redirect_o,
  output logic              recover_o,
  output logic              fd_flush_o,
  output logic              dx_flush_o
);
  logic            br_hit;
  logic [PC_W-1:0] br_target;
  logic [PC_W-1:0] seq_pc;
  logic            mispredict;
  slot_t           fetch_slot;
  slot_t           dx_slot;

  br_decode #(
    .INSN_W(INSN_W), .OPC_LSB(OPC_LSB), .OPC_W(OPC_W),
    .BR_OPC(BR_OPC), .OFF_W(OFF_W), .ALIGN_SH(ALIGN_SH)
  ) u_dec (
    .pc(pc_o), .insn(insn_i), .insn_valid(insn_valid_i),
    .is_br(br_hit), .target(br_target), .seq_pc(seq_pc)
  );

  always_comb begin
    fetch_slot.live    = insn_valid_i;
    fetch_slot.is_br   = br_hit;
    fetch_slot.fall_pc = seq_pc;
    redirect_o         = br_hit && !mispredict;
    recover_o          = mispredict;
  end

  slot_track u_track (
    .clk(clk), .rst_n(rst_n), .fetch_slot(fetch_slot), .ex_zero(ex_zero_i),
    .dx_slot(dx_slot), .mispredict(mispredict),
    .fd_flush(fd_flush_o), .dx_flush(dx_flush_o)
  );

  pc_unit #(.RESET_PC(RESET_PC), .ALIGN_SH(ALIGN_SH)) u_pc (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid_i),
    .redirect(redirect_o), .target(br_target), .seq_pc(seq_pc),
    .recover(mispredict), .recover_pc(dx_slot.fall_pc), .pc_q(pc_o)
  );

  // R8: recovery outranks a same-cycle redirect
  a_r8_recover_wins: assert property (@(posedge clk) disable iff (!rst_n)
    recover_o |-> !redirect_o);

  // R7: both flush strobes accompany every recovery
  a_r7_flush_pair: assert property (@(posedge clk) disable iff (!rst_n)
    recover_o |-> (fd_flush_o && dx_flush_o));
endmodule

// File: tb/sim_taken_fetch.sv
`timescale 1ns/1ps
module sim_taken_fetch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] insn = '0;
  logic        vld = 1'b0;
  logic        zero = 1'b0;
  logic [31:0] pc;
  logic        redir, recov, fdf, dxf;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  taken_fetch u0 (
    .clk(clk), .rst_n(rst_n), .insn_i(insn), .insn_valid_i(vld),
    .ex_zero_i(zero), .pc_o(pc), .redirect_o(redir), .recover_o(recov),
    .fd_flush_o(fdf), .dx_flush_o(dxf)
  );

  // Reference state, built from the requirements
  logic [31:0] m_pc;
  logic        f_live, f_br, d_live, d_br;
  logic [31:0] f_fall, d_fall;
  string       pc_tag;

  function automatic bit is_branch(input logic [31:0] w, input logic v);
    return v && (w[31:26] == 6'h04);
  endfunction

  function automatic logic [31:0] tgt_of(input logic [31:0] p, input logic [31:0] w);
    logic [31:0] ext;
    ext = {{16{w[15]}}, w[15:0]};
    return p + (ext << 2);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle, check combinational outputs and pc, then advance model
  task automatic step(input logic [31:0] w, input logic v, input logic z);
    logic rec, br;
    @(negedge clk);
    insn = w; vld = v; zero = z;
    #1;
    check(pc_tag, pc, m_pc);
    rec = d_live && d_br && !z;
    br  = is_branch(w, v) && !rec;
    check(rec && is_branch(w, v) ? "R8" : (v ? "R4" : "R3"), {31'd0, redir}, {31'd0, br});
    check(d_live && d_br ? (z ? "R5" : "R6") : "R9", {31'd0, recov}, {31'd0, rec});
    check("R7", {30'd0, fdf, dxf}, {30'd0, rec, rec});
    if (rec) begin
      pc_tag = is_branch(w, v) ? "R8" : "R6";
      d_live = 0; d_br = 0; d_fall = '0;
      f_live = 0; f_br = 0; f_fall = '0;
      m_pc = d_fall_saved(rec);
    end else begin
      d_live = f_live; d_br = f_br; d_fall = f_fall;
      f_live = v; f_br = is_branch(w, v); f_fall = m_pc + 32'd4;
      if (!v) begin pc_tag = "R3"; end
      else if (br) begin pc_tag = "R4"; m_pc = tgt_of(m_pc, w); end
      else begin pc_tag = "R2"; m_pc = m_pc + 32'd4; end
    end
  endtask

  logic [31:0] saved_fall;
  function automatic logic [31:0] d_fall_saved(input logic r);
    return r ? saved_fall : '0;
  endfunction

  task automatic run(input logic [31:0] w, input logic v, input logic z);
    saved_fall = d_fall;
    step(w, v, z);
  endtask

  function automatic logic [31:0] mk_br(input logic [15:0] off);
    return {6'h04, 10'h000, off};
  endfunction

  function automatic logic [31:0] mk_alu(input logic [25:0] body);
    return {6'h23, body};
  endfunction

  initial begin
    void'($urandom(32'd2718));
    m_pc = '0; pc_tag = "R1";
    f_live = 0; f_br = 0; f_fall = '0; d_live = 0; d_br = 0; d_fall = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", pc, 32'd0);
    check("R1", {28'd0, redir, recov, fdf, dxf}, 32'd0);
    rst_n = 1'b1;

    // directed: step, bubble, backward branch kept (zero=1)
    run(mk_alu(26'h1), 1, 0);
    run(mk_alu(26'h2), 0, 0);
    run(mk_br(16'hFFFD), 1, 0);
    run(mk_alu(26'h3), 1, 0);
    run(mk_alu(26'h4), 1, 1);   // R5: branch in execute, operand zero
    // mispredict with a branch being fetched in the same cycle (R8)
    run(mk_br(16'h0010), 1, 1);
    run(mk_alu(26'h5), 1, 0);
    run(mk_br(16'h0020), 1, 0); // R6 + R8
    // flushed branch must not resolve (R9)
    run(mk_br(16'h0008), 1, 1);
    run(mk_br(16'h0008), 1, 0);
    run(mk_alu(26'h6), 1, 0);
    run(mk_alu(26'h7), 1, 0);
    run(mk_alu(26'h8), 1, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      w = $urandom;
      if ($urandom % 10 < 3) w[31:26] = 6'h04;
      else if (w[31:26] == 6'h04) w[31:26] = 6'h05;
      run(w, ($urandom % 100) < 85, $urandom % 2 == 0);
    end
    @(negedge clk);
    check(pc_tag, pc, m_pc);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule